// File: doc/BRIEF.md
# Reloading Interval Timer with Selectable Prescaler

This block is an 8-bit down-counting interval timer for a small microcontroller. The system clock feeds an 8-bit divider, and a 3-bit select code picks the tap that paces the counter, from divide-by-2 up to divide-by-256. Each paced tick lowers the live count by one. When the count stands at one, the next tick loads the reload value back in place of going to zero. That same tick raises a one-cycle interrupt request toward an external flag register, if interrupts are enabled.

Software writes a nonzero reload value, which sets both the stored reload value and the live count. It sets the select code and then turns the timer on. It can read the live count at any time, and the count is always between 1 and the reload value. A write of zero is illegal, and the block drops it. The interrupt period in system clock cycles is the reload value times the selected divide ratio.

Top module: `interval_timer`

## Requirements
- R1: After reset the live count and the stored reload value are both 255, and `irqPulse` is low.
- R2: Select code s (0 to 7) makes one counter tick every 2^(s+1) system clock cycles. The divider is cleared while `timerEn` is low, so the first tick falls at the end of the 2^(s+1)-th enabled cycle.
- R3: Each tick lowers the live count by one. A tick that finds the count at 1 loads the reload value instead, so `count` never reads 0.
- R4: `irqPulse` is high for exactly one cycle, in the cycle after the tick that reloads the counter. With reload value N, pulses are N*2^(s+1) cycles apart.
- R5: While `irqEn` is low no pulse is issued, and counting goes on unchanged.
- R6: A write with `loadWe` high and a nonzero `loadData` sets both the reload value and the live count in the next cycle. This holds whether or not the timer is enabled, and a write overrides a tick in the same cycle.
- R7: A write of zero is ignored. The live count and the reload value both stay as they were.
- R8: While `timerEn` is low and no write occurs, the live count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| loadWe | input | 1 | Write strobe for the reload value |
| loadData | input | 8 | Reload value to write (1 to 255) |
| clkSel | input | 3 | Prescaler select: divide by 2^(clkSel+1) |
| timerEn | input | 1 | Counter enable; low clears the prescaler |
| irqEn | input | 1 | Interrupt request enable |
| count | output | 8 | Live count readback |
| irqPulse | output | 1 | One-cycle interrupt request on each expiry |

## Verification
The assertions assume that every input is synchronous to `clk` and holds a known value from the first cycle after reset. They also assume that the zero-write and hold rules apply only while the timer is off. The stimulus drives every input on the falling edge and keeps `loadWe` to single-cycle strobes. It changes `clkSel` and `irqEn` only while the timer is disabled, so each expected interrupt cycle follows directly from the enable edge, the reload value and the select code.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CNT_W = 8;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic load;  // accepted nonzero write
    logic tick;  // prescaler period elapsed
    logic wrap;  // tick while count sits at one
  } tmrStrobe_t;
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int SEL_W = 3,
  localparam int PRE_W = 2 ** SEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] tapHit;

  always_ff @(posedge clk) begin
    if (!rstN || !run) preCnt <= '0;
    else               preCnt <= preCnt + 1'b1;
  end

  // tap i fires once every 2^(i+1) cycles, when the low i+1 bits are all ones
  for (genvar i = 0; i < PRE_W; i++) begin : gTap
    assign tapHit[i] = &preCnt[i:0];
  end

  assign tick = run && tapHit[sel];
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int W = CNT_W,
  parameter int S = SEL_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadWe,
  input  logic [W-1:0] loadData,
  input  logic [S-1:0] clkSel,
  input  logic         timerEn,
  input  logic         irqEn,
  input  logic         atOne,
  output tmrStrobe_t   strobe,
  output logic         irqPulse
);
  logic tickRaw;
  logic irqQ;

  timer_prescaler #(.SEL_W(S)) uPre (
    .clk (clk),
    .rstN(rstN),
    .run (timerEn),
    .sel (clkSel),
    .tick(tickRaw)
  );

  always_comb begin
    strobe.load = loadWe && (loadData != '0);
    strobe.tick = tickRaw;
    strobe.wrap = tickRaw && atOne && !strobe.load;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= strobe.wrap && irqEn;
  end

  assign irqPulse = irqQ;
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  tmrStrobe_t   strobe,
  input  logic [W-1:0] loadData,
  output logic [W-1:0] count,
  output logic         atOne
);
  localparam logic [W-1:0] RST_VAL = '1;
  localparam logic [W-1:0] ONE     = W'(1);

  logic [W-1:0] reloadQ;
  logic [W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= RST_VAL;
      countQ  <= RST_VAL;
    end else if (strobe.load) begin
      reloadQ <= loadData;
      countQ  <= loadData;
    end else if (strobe.wrap) begin
      countQ  <= reloadQ;
    end else if (strobe.tick) begin
      countQ  <= countQ - ONE;
    end
  end

  assign atOne = (countQ == ONE);
  assign count = countQ;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadWe,
  input  logic [CNT_W-1:0] loadData,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             timerEn,
  input  logic             irqEn,
  output logic [CNT_W-1:0] count,
  output logic             irqPulse
);
  tmrStrobe_t strobe;
  logic       atOne;

  timer_ctrl #(.W(CNT_W), .S(SEL_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadWe  (loadWe),
    .loadData(loadData),
    .clkSel  (clkSel),
    .timerEn (timerEn),
    .irqEn   (irqEn),
    .atOne   (atOne),
    .strobe  (strobe),
    .irqPulse(irqPulse)
  );

  timer_datapath #(.W(CNT_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .loadData(loadData),
    .count   (count),
    .atOne   (atOne)
  );
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk
  import timer_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             loadWe,
  input logic [CNT_W-1:0] loadData,
  input logic             timerEn,
  input logic             irqEn,
  input logic [CNT_W-1:0] count,
  input logic             irqPulse
);
  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    count != '0);  // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (timerEn && !loadWe && count > 8'd1) |=> (count == $past(count) || count == $past(count) - 8'd1));  // R3
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);  // R4
  AST_IRQ_FROM_ONE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> ($past(count) == 8'd1 && $past(timerEn)));  // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |=> !irqPulse);  // R5
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (loadWe && loadData != '0) |=> count == $past(loadData));  // R6
  AST_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (loadWe && loadData == '0 && !timerEn) |=> $stable(count));  // R7
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!timerEn && !loadWe) |=> $stable(count));  // R8
endmodule

bind interval_timer interval_timer_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .loadWe  (loadWe),
  .loadData(loadData),
  .timerEn (timerEn),
  .irqEn   (irqEn),
  .count   (count),
  .irqPulse(irqPulse)
);

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadWe = 1'b0;
  logic [7:0] loadData = '0;
  logic [2:0] clkSel = '0;
  logic       timerEn = 1'b0;
  logic       irqEn = 1'b0;
  logic [7:0] count;
  logic       irqPulse;

  int checks = 0;
  int failures = 0;
  int edgeCnt = 0;
  int expQ[$];

  interval_timer dut (
    .clk(clk), .rstN(rstN), .loadWe(loadWe), .loadData(loadData),
    .clkSel(clkSel), .timerEn(timerEn), .irqEn(irqEn),
    .count(count), .irqPulse(irqPulse)
  );

  always #10 clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the expected pulse cycle for each observed pulse
  always @(negedge clk) begin
    if (rstN && irqPulse) begin
      if (expQ.size() == 0) check(1'b0, "R5 unexpected irq", edgeCnt, -1);
      else begin
        int e;
        e = expQ.pop_front();
        check(edgeCnt == e, "R4 irq timing", edgeCnt, e);
      end
    end
    if (rstN && count == 8'd0) check(1'b0, "R3 count zero", 0, 1);
  end

  task automatic writeReload(input logic [7:0] v);
    loadWe = 1'b1; loadData = v;
    @(negedge clk);
    loadWe = 1'b0; loadData = '0;
  endtask

  task automatic waitEdge(input int target);
    while (edgeCnt < target) @(negedge clk);
  endtask

  // driver: runs K periods with reload N and select s, pushing expected pulses
  task automatic runTimer(input int s, input int n, input int k, input bit irqOn, input bit skipLoad);
    int d;
    int e0;
    d = 1 << (s + 1);
    if (!skipLoad) begin
      writeReload(8'(n));
      check(count == 8'(n), "R6 load while disabled", count, n);
    end
    clkSel = 3'(s); irqEn = irqOn;
    timerEn = 1'b1;
    e0 = edgeCnt + 1;
    if (irqOn) for (int i = 1; i <= k; i++) expQ.push_back(e0 + i * n * d - 1);
    waitEdge(e0 + d - 2);
    check(count == 8'(n), "R2 no tick before divide ratio", count, n);
    waitEdge(e0 + d - 1);
    check(count == 8'((n == 1) ? n : n - 1), "R3 first tick", count, (n == 1) ? n : n - 1);
    waitEdge(e0 + k * n * d - 1);
    check(count == 8'(n), "R3 reload after expiry", count, n);
    timerEn = 1'b0;
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R4 all pulses seen", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(count == 8'd255, "R1 reset count", count, 255);
    check(irqPulse == 1'b0, "R1 reset irq", irqPulse, 0);

    runTimer(0, 1, 3, 1'b1, 1'b0);   // R4 fastest pulse train
    runTimer(2, 5, 2, 1'b1, 1'b0);   // R2 divide by 8
    runTimer(7, 2, 2, 1'b1, 1'b0);   // R2 divide by 256
    runTimer(1, 255, 1, 1'b1, 1'b0); // R3 full range
    runTimer(3, 4, 2, 1'b0, 1'b0);   // R5 irq disabled, no pulses expected

    begin : holdTest  // R8
      logic [7:0] held;
      held = count;
      repeat (20) @(negedge clk);
      check(count == held, "R8 hold while disabled", count, held);
    end

    begin : liveWrite  // R6 write while counting
      writeReload(8'd10);
      clkSel = 3'd0; irqEn = 1'b0; timerEn = 1'b1;
      repeat (7) @(negedge clk);
      writeReload(8'd3);
      check(count == 8'd3, "R6 load while enabled", count, 3);
      timerEn = 1'b0;
      @(negedge clk);
    end

    begin : zeroWrite  // R7
      writeReload(8'd3);
      writeReload(8'd0);
      check(count == 8'd3, "R7 zero write ignored", count, 3);
      runTimer(0, 3, 2, 1'b1, 1'b1);  // reload value must still be 3
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule